// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off state of every switch in an 8-column by 12-row crosspoint matrix. There are 96 control bits, one per crosspoint, and all of them leave the block in parallel on a 96-bit vector that drives the switch gates. A controller writes one bit at a time. It presents a 7-bit cell address and a data bit, raises the select line, and pulses the strobe. A separate clear line empties the whole memory.

The block is synchronous. All write-side inputs pass through a two-flop synchroniser, so they may come from a slow or asynchronous controller. The addressed bit behaves like a transparent latch. While select and strobe are both high it tracks the data bit. When strobe drops, it keeps the last data value it saw. Several blocks can share one address/data/strobe bus, with each block enabled by its own select line.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `sw_on` is 0 after that edge.
- R2: Address bits [2:0] select the column y (0..7) and bits [6:3] select the row x (0..11). The cell for column y and row x drives `sw_on[x*8+y]`.
- R3: A cell is written only while `sel_in` and `stb_in` are both high. With `sel_in` low, strobe pulses leave `sw_on` unchanged.
- R4: While a write is enabled, the addressed output bit follows `data_in`, including changes made while the strobe is high.
- R5: The cell keeps the `data_in` value it held when the strobe fell. Later changes to `data_in` with the strobe low do not alter `sw_on`.
- R6: A write alters only the addressed bit; all other bits of `sw_on` keep their values.
- R7: Writing 1 sets the addressed bit (switch on). Writing 0 clears it (switch off).
- R8: `wipe_in` high clears all 96 bits whatever the level of `sel_in`, and it overrides a write that is enabled at the same time.
- R9: Row codes 12 to 15 address no cell. A write with such a code leaves `sw_on` unchanged.
- R10: An input change made just after a clock edge first shows on `sw_on` after the third following rising edge (two synchroniser stages plus the cell register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of synchroniser and cells |
| addr_in | input | 7 | Cell address: [2:0] column, [6:3] row |
| data_in | input | 1 | Value to write (1 = switch on) |
| sel_in | input | 1 | Active-high select for cascading |
| stb_in | input | 1 | Active-high write strobe |
| wipe_in | input | 1 | Active-high clear of all cells |
| sw_on | output | 96 | Switch controls, bit x*8+y for row x, column y |

## Verification
The hardest case to reach is an open write window that meets another event while still open. One such event is a change of `data_in` with the strobe held high. The other is a clear that lands while select and strobe are both asserted. The bench holds the strobe high across several data toggles and checks the bit after each toggle. It then raises the clear in the middle of an open write and drops it again, so the cell reopens to the data value, and only after that closes the strobe. The timing of the output is pinned down by sampling the bit on each of the edges around the three-cycle latency.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic wipe;
    logic sel;
    logic stb;
    logic data;
  } xpt_ctl_t;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(STAGES); k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < int'(STAGES); k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/xpt_decode.sv
module xpt_decode #(
  parameter int unsigned NCOL  = 8,
  parameter int unsigned NROW  = 12,
  parameter int unsigned COL_W = 3,
  parameter int unsigned ROW_W = 4,
  parameter int unsigned NCELL = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             go,
  output logic [NCELL-1:0] we
);
  for (genvar x = 0; x < int'(NROW); x++) begin : g_row
    for (genvar y = 0; y < int'(NCOL); y++) begin : g_col
      assign we[x*NCOL+y] = go && (int'(row) == x) && (int'(col) == y);
    end
  end

  // R6
  we_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(we));

  // R9
  bad_row_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(row) >= int'(NROW)) |-> (we == '0));
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
  parameter int unsigned NCELL = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic [NCELL-1:0] we,
  input  logic             d,
  output logic [NCELL-1:0] q
);
  for (genvar i = 0; i < int'(NCELL); i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst || wipe) q[i] <= 1'b0;
      else if (we[i])  q[i] <= d;
    end

    // R6
    hold_cell_chk: assert property (@(posedge clk) disable iff (rst)
      (!wipe && !we[i]) |=> $stable(q[i]));

    // R4
    follow_cell_chk: assert property (@(posedge clk) disable iff (rst)
      (!wipe && we[i]) |=> (q[i] == $past(d)));
  end

  // R8
  wipe_all_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (q == '0));
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int unsigned NCOL = 8,
  parameter int unsigned NROW = 12
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [$clog2(NCOL)+$clog2(NROW)-1:0]    addr_in,
  input  logic                                    data_in,
  input  logic                                    sel_in,
  input  logic                                    stb_in,
  input  logic                                    wipe_in,
  output logic [NCOL*NROW-1:0]                    sw_on
);
  import xpt_pkg::*;

  localparam int unsigned COL_W  = $clog2(NCOL);
  localparam int unsigned ROW_W  = $clog2(NROW);
  localparam int unsigned ADDR_W = COL_W + ROW_W;
  localparam int unsigned NCELL  = NCOL * NROW;
  localparam int unsigned SYNC_W = ADDR_W + $bits(xpt_ctl_t);

  xpt_ctl_t          ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [NCELL-1:0]  we;
  logic              go;

  assign ctl_raw = '{wipe: wipe_in, sel: sel_in, stb: stb_in, data: data_in};

  xpt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({addr_in, ctl_raw}),
    .dout ({addr_s, ctl_s})
  );

  assign go = ctl_s.sel && ctl_s.stb;

  xpt_decode #(
    .NCOL(NCOL), .NROW(NROW), .COL_W(COL_W), .ROW_W(ROW_W), .NCELL(NCELL)
  ) u_dec (
    .clk (clk),
    .rst (rst),
    .col (addr_s[COL_W-1:0]),
    .row (addr_s[ADDR_W-1:COL_W]),
    .go  (go),
    .we  (we)
  );

  xpt_cell_array #(.NCELL(NCELL)) u_cells (
    .clk  (clk),
    .rst  (rst),
    .wipe (ctl_s.wipe),
    .we   (we),
    .d    (ctl_s.data),
    .q    (sw_on)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sw_on == '0));

  // R5
  strobe_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.stb && !ctl_s.wipe) |=> $stable(sw_on));

  // R3
  unselected_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_s.sel && !ctl_s.wipe) |=> $stable(sw_on));
endmodule

// File: tb/xpt_ctrl_mem_bench.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  addr_in = '0;
  logic        data_in = 1'b0;
  logic        sel_in = 1'b0;
  logic        stb_in = 1'b0;
  logic        wipe_in = 1'b0;
  logic [95:0] sw_on;

  logic [95:0] exp_v = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xpt_ctrl_mem u_xpt_ctrl_mem (
    .clk(clk), .rst(rst), .addr_in(addr_in), .data_in(data_in),
    .sel_in(sel_in), .stb_in(stb_in), .wipe_in(wipe_in), .sw_on(sw_on)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Full strobe pulse; model updates only for a selected, valid row
  task automatic do_write(input int a, input logic d, input logic s);
    addr_in = 7'(a); data_in = d; sel_in = s; stb_in = 1'b0;
    wait_cyc(4);
    stb_in = 1'b1;
    wait_cyc(4);
    stb_in = 1'b0;
    wait_cyc(4);
    if (s && (a / 8) < 12) exp_v[(a / 8) * 8 + (a % 8)] = d;
  endtask

  initial begin
    wait_cyc(3);
    check("R1 reset state", sw_on, '0);
    rst = 1'b0;
    wait_cyc(2);
    check("R1 after release", sw_on, '0);

    // R2 R9 R6 R7: sweep every address code writing 1
    for (int a = 0; a < 128; a++) begin
      do_write(a, 1'b1, 1'b1);
      check((a / 8) < 12 ? "R2 R6 R7 set sweep" : "R9 invalid row", sw_on, exp_v);
    end

    // R3: unselected strobes do nothing
    for (int a = 0; a < 96; a += 7) begin
      do_write(a, 1'b0, 1'b0);
      check("R3 unselected", sw_on, exp_v);
    end

    // R8: clear with select low
    sel_in = 1'b0; wipe_in = 1'b1;
    wait_cyc(4);
    wipe_in = 1'b0;
    exp_v = '0;
    wait_cyc(4);
    check("R8 clear unselected", sw_on, exp_v);

    // R6 R7: checker pattern by writes
    for (int x = 0; x < 12; x++)
      for (int y = 0; y < 8; y++) begin
        do_write(x * 8 + y, 1'((x * 3 + y) % 2), 1'b1);
        check("R6 R7 pattern", sw_on, exp_v);
      end
    for (int x = 0; x < 12; x += 2)
      for (int y = 1; y < 8; y += 2) begin
        do_write(x * 8 + y, 1'b0, 1'b1);
        check("R7 write zero", sw_on, exp_v);
      end

    // R4 R5: transparency and capture at strobe fall (row 11, col 6)
    addr_in = 7'(11 * 8 + 6); sel_in = 1'b1; data_in = 1'b1;
    wait_cyc(4);
    stb_in = 1'b1;
    wait_cyc(4);
    exp_v[94] = 1'b1;
    check("R4 follow high", sw_on, exp_v);
    data_in = 1'b0;
    wait_cyc(4);
    exp_v[94] = 1'b0;
    check("R4 follow low", sw_on, exp_v);
    data_in = 1'b1;
    wait_cyc(4);
    exp_v[94] = 1'b1;
    check("R4 follow high again", sw_on, exp_v);
    stb_in = 1'b0;
    wait_cyc(4);
    data_in = 1'b0;
    wait_cyc(4);
    check("R5 hold after fall", sw_on, exp_v);

    // R10: latency of three rising edges (row 0, col 3)
    addr_in = 7'd3; data_in = 1'b1; sel_in = 1'b1;
    wait_cyc(4);
    stb_in = 1'b1;
    wait_cyc(2);
    check("R10 not yet after two edges", sw_on, exp_v);
    wait_cyc(1);
    exp_v[3] = 1'b1;
    check("R10 visible after three edges", sw_on, exp_v);
    stb_in = 1'b0;
    wait_cyc(4);

    // R8: clear overrides an open write, write resumes when clear drops
    addr_in = 7'(5 * 8 + 2); data_in = 1'b1; sel_in = 1'b1;
    wait_cyc(4);
    stb_in = 1'b1; wipe_in = 1'b1;
    wait_cyc(4);
    check("R8 clear overrides write", sw_on, '0);
    wipe_in = 1'b0;
    wait_cyc(4);
    exp_v = '0;
    exp_v[42] = 1'b1;
    check("R8 reopen after clear", sw_on, exp_v);
    stb_in = 1'b0;
    wait_cyc(4);
    check("R5 final hold", sw_on, exp_v);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule